// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. After reset it walks one fixed series of commands on the memory command pins: a long settling wait filled with no-operation commands, one precharge of every bank, two auto-refresh commands each followed by its recovery time, and finally a load of the mode register. It then raises a done flag. A busy flag, the inverse of done, holds off the main access controller until the memory can accept traffic.

The mode word (burst length, burst ordering, CAS latency and write-burst behaviour) comes in on plain inputs. It is captured while reset is held and packed onto the address pins when the mode register is loaded. A CAS latency code other than the two legal settings is replaced by a latency of three, and a sticky flag reports the substitution. All wait lengths are parameters, so a bench can shorten them. The defaults match a 100 us settle at 133 MHz.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While rst_n is low (sampled at a clock edge), the block outputs command inhibit (sd_cs_n = 1), init_busy = 1 and init_done = 0.
- R2: For the first PWRUP_CYC cycles after reset is released, the command pins {cs_n, ras_n, cas_n, we_n} carry NOP = 4'b0111, with sd_addr = 0 and sd_ba = 0.
- R3: The next cycle carries one PRECHARGE (4'b0010) with sd_addr[10] = 1 (sd_addr = 12'h400), so all banks are closed.
- R4: The first AUTO REFRESH (4'b0001) is issued exactly TRP_CYC cycles after the PRECHARGE, and NOPs fill the cycles in between.
- R5: The second AUTO REFRESH follows the first by exactly TRFC_CYC cycles, and the LOAD MODE REGISTER follows the second by exactly TRFC_CYC cycles, with NOPs in between.
- R6: LOAD MODE REGISTER is 4'b0000. Its sd_addr holds the burst length on bits 2:0, the burst type on bit 3 (1 = interleaved), the CAS latency on bits 6:4, 2'b00 on bits 8:7, write-single mode on bit 9, and 2'b00 on bits 11:10.
- R7: CAS latency codes 3'd2 and 3'd3 pass through unchanged, and cas_fixed stays 0. Any other code is sent as 3'd3, and cas_fixed is 1 from the first cycle after reset release until the next reset.
- R8: init_done rises exactly TMRD_CYC cycles after the LOAD MODE REGISTER and then stays high with NOP on the pins. init_busy is always the inverse of init_done.
- R9: sd_cke is 1 in every cycle, including during reset.
- R10: The mode inputs are captured while reset is held. Changing them after reset is released has no effect on the word that the LOAD MODE REGISTER puts on the address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new sequence |
| mode_burst_len | input | 3 | Burst length code |
| mode_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| mode_cas_lat | input | 3 | Requested CAS latency code |
| mode_wr_single | input | 1 | 1 = writes are single-location |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins |
| sd_ba | output | 2 | Bank select pins |
| sd_cke | output | 1 | Clock enable |
| init_done | output | 1 | Sequence complete |
| init_busy | output | 1 | Sequence in progress |
| cas_fixed | output | 1 | Reserved CAS latency was replaced |

## Verification
The sequencer state and the wait counter together decide every pin in every cycle. A wrong state or a miscounted wait therefore shows up as a command in the wrong cycle, or a command of the wrong kind. This is visible in the very cycle the fault happens, because the command stream is compared cycle by cycle against an independently built schedule. A bad mode capture or a bad latency substitution only appears on the single LOAD MODE REGISTER cycle and on cas_fixed. For that reason, several mode words are run, including reserved latencies and inputs changed after reset is released.

// File: rtl/sdram_init_pkg.sv
// Shared definitions for the SDRAM power-up sequencer.
// Command codes are the pin values {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'b1111,
        CMD_NOP     = 4'b0111,
        CMD_PRECHG  = 4'b0010,
        CMD_REFRESH = 4'b0001,
        CMD_LOADMR  = 4'b0000
    } sd_cmd_t;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_SETTLE,
        ST_PRECHG,
        ST_WAIT_RP,
        ST_REF_A,
        ST_WAIT_RFC_A,
        ST_REF_B,
        ST_WAIT_RFC_B,
        ST_LOADMR,
        ST_WAIT_MRD,
        ST_READY
    } seq_state_t;

    // Mode word field positions on the address bus (decoded by the memory)
    localparam int MW_BL_LSB  = 0;
    localparam int MW_BT_BIT  = 3;
    localparam int MW_CL_LSB  = 4;
    localparam int MW_WB_BIT  = 9;
    localparam int ALL_BANK_BIT = 10;

    localparam logic [2:0] CL_TWO   = 3'd2;
    localparam logic [2:0] CL_THREE = 3'd3;

endpackage

// File: rtl/init_wait_timer.sv
// Down-counter for the waits between commands.
// Assumes: load has priority; the count holds at zero until the next load.
module init_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new wait, or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/init_mode_packer.sv
// Packs the mode fields into the address word for the mode register load.
// Replaces a reserved CAS latency with three and flags the replacement.
// Assumes: ADDR_W >= 12; bits above the defined fields stay zero.
module init_mode_packer #(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        burst_len,
    input  logic              interleave,
    input  logic [2:0]        cas_lat,
    input  logic              wr_single,
    output logic [ADDR_W-1:0] word,
    output logic              cl_replaced
);
    import sdram_init_pkg::*;

    logic       cl_ok;
    logic [2:0] cl_used;

    // Choose a legal CAS latency
    always_comb begin
        cl_ok   = (cas_lat == CL_TWO) || (cas_lat == CL_THREE);
        cl_used = cl_ok ? cas_lat : CL_THREE;
    end

    // Place the fields; op-mode and reserved bits remain zero
    always_comb begin
        word = '0;
        word[MW_BL_LSB +: 3] = burst_len;
        word[MW_BT_BIT]      = interleave;
        word[MW_CL_LSB +: 3] = cl_used;
        word[MW_WB_BIT]      = wr_single;
    end

    assign cl_replaced = !cl_ok;
endmodule

// File: rtl/init_cmd_drive.sv
// Splits a command code onto the individual SDRAM command pins.
// Assumes: the code enumeration equals the pin levels.
module init_cmd_drive (
    input  sdram_init_pkg::sd_cmd_t cmd,
    output logic                    cs_n,
    output logic                    ras_n,
    output logic                    cas_n,
    output logic                    we_n
);
    // Drive each pin from its bit of the code
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end
endmodule

// File: rtl/sdram_powerup_seq.sv
// SDRAM power-up sequencer: settle wait, precharge all, two auto refreshes,
// mode register load, then ready.
// Assumes: TRP_CYC, TRFC_CYC, TMRD_CYC >= 2 (smaller values act as 2);
// the mode inputs are valid while rst_n is low.
module sdram_powerup_seq #(
    parameter int PWRUP_CYC = 13300,
    parameter int TRP_CYC   = 3,
    parameter int TRFC_CYC  = 9,
    parameter int TMRD_CYC  = 2,
    parameter int ADDR_W    = 12,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_burst_len,
    input  logic              mode_interleave,
    input  logic [2:0]        mode_cas_lat,
    input  logic              mode_wr_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              sd_cke,
    output logic              init_done,
    output logic              init_busy,
    output logic              cas_fixed
);
    import sdram_init_pkg::*;

    localparam int MAX_WAIT = (PWRUP_CYC > TRFC_CYC) ? PWRUP_CYC : TRFC_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int PW_LD    = (PWRUP_CYC > 1) ? PWRUP_CYC - 1 : 0;
    localparam int RP_LD    = (TRP_CYC  > 2) ? TRP_CYC  - 2 : 0;
    localparam int RFC_LD   = (TRFC_CYC > 2) ? TRFC_CYC - 2 : 0;
    localparam int MRD_LD   = (TMRD_CYC > 2) ? TMRD_CYC - 2 : 0;

    seq_state_t        state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [ADDR_W-1:0] packed_word;
    logic              packed_fix;
    logic [ADDR_W-1:0] mode_q;
    logic              fix_q;
    sd_cmd_t           cmd;

    init_mode_packer #(.ADDR_W(ADDR_W)) u_pack (
        .burst_len   (mode_burst_len),
        .interleave  (mode_interleave),
        .cas_lat     (mode_cas_lat),
        .wr_single   (mode_wr_single),
        .word        (packed_word),
        .cl_replaced (packed_fix)
    );

    init_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Capture the mode word while reset is held; keep it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= packed_word;
            fix_q  <= packed_fix;
        end
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Next state and wait loads; each command state lasts one cycle
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_RESET: begin
                state_d  = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PW_LD);
            end
            ST_SETTLE:     if (tmr_expired) state_d = ST_PRECHG;
            ST_PRECHG: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RP_LD);
            end
            ST_WAIT_RP:    if (tmr_expired) state_d = ST_REF_A;
            ST_REF_A: begin
                state_d  = ST_WAIT_RFC_A;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RFC_LD);
            end
            ST_WAIT_RFC_A: if (tmr_expired) state_d = ST_REF_B;
            ST_REF_B: begin
                state_d  = ST_WAIT_RFC_B;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RFC_LD);
            end
            ST_WAIT_RFC_B: if (tmr_expired) state_d = ST_LOADMR;
            ST_LOADMR: begin
                state_d  = ST_WAIT_MRD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(MRD_LD);
            end
            ST_WAIT_MRD:   if (tmr_expired) state_d = ST_READY;
            ST_READY:      state_d = ST_READY;
            default:       state_d = ST_RESET;
        endcase
    end

    // Command and address selection per state
    always_comb begin
        sd_addr = '0;
        unique case (state_q)
            ST_RESET:  cmd = CMD_INHIBIT;
            ST_PRECHG: begin
                cmd = CMD_PRECHG;
                sd_addr[ALL_BANK_BIT] = 1'b1;
            end
            ST_REF_A, ST_REF_B: cmd = CMD_REFRESH;
            ST_LOADMR: begin
                cmd     = CMD_LOADMR;
                sd_addr = mode_q;
            end
            default:   cmd = CMD_NOP;
        endcase
    end

    init_cmd_drive u_drive (
        .cmd   (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    assign sd_ba     = '0;
    assign sd_cke    = 1'b1;
    assign init_done = (state_q == ST_READY);
    assign init_busy = !init_done;
    assign cas_fixed = fix_q;
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
// Property checker for the power-up sequencer, bound to the top module.
// Assumes: TMRD_CYC fits the local cycle counter.
module sdram_powerup_seq_chk #(
    parameter int TMRD_CYC = 2,
    parameter int ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done,
    input logic              init_busy
);
    logic [3:0] pins;
    logic       is_loadmr;
    logic [7:0] since_mr;

    assign pins      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_loadmr = (pins == 4'b0000);

    // Count cycles elapsed since the mode register load
    always_ff @(posedge clk) begin
        if (!rst_n)                             since_mr <= '0;
        else if (is_loadmr)                     since_mr <= 8'd1;
        else if (since_mr != '0 && !init_done)  since_mr <= since_mr + 1'b1;
    end

    // R1
    reset_inhibit_chk: assert property (@(posedge clk) !rst_n |=> sd_cs_n);

    // R3
    prechg_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> sd_addr[10]);

    // R6
    mode_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_loadmr |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00));

    // R7
    mode_cl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_loadmr |-> (sd_addr[6:4] == 3'd2 || sd_addr[6:4] == 3'd3));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy != init_done);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == 4'b0111));

    // R8
    done_after_mrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (since_mr == 8'(TMRD_CYC)));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
    .TMRD_CYC (TMRD_CYC),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .init_done (init_done),
    .init_busy (init_busy)
);

// File: tb/sdram_powerup_seq_test.sv
// Scoreboard bench: the driver builds the expected per-cycle pin stream,
// the monitor pops one item per cycle and compares.
`timescale 1ns/1ps
module sdram_powerup_seq_test;
    localparam int PW   = 20;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int TMRD = 2;

    typedef struct packed {
        logic [31:0] tag;
        logic [3:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  ba;
        logic        cke;
        logic        busy;
        logic        done;
        logic        fix;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] m_bl = '0;
    logic       m_bt = 1'b0;
    logic [2:0] m_cl = 3'd2;
    logic       m_wb = 1'b0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba;
    logic init_done, init_busy, cas_fixed;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    sdram_powerup_seq #(
        .PWRUP_CYC (PW), .TRP_CYC (TRP), .TRFC_CYC (TRFC), .TMRD_CYC (TMRD)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .mode_burst_len (m_bl), .mode_interleave (m_bt),
        .mode_cas_lat (m_cl), .mode_wr_single (m_wb),
        .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n),
        .sd_we_n (sd_we_n), .sd_addr (sd_addr), .sd_ba (sd_ba),
        .sd_cke (sd_cke), .init_done (init_done), .init_busy (init_busy),
        .cas_fixed (cas_fixed)
    );

    task automatic push(input logic [31:0] tag, input logic [3:0] cmd,
                        input logic [11:0] addr, input logic done, input logic fix);
        exp_t e;
        e.tag = tag; e.cmd = cmd; e.addr = addr; e.ba = 2'b00; e.cke = 1'b1;
        e.busy = !done; e.done = done; e.fix = fix;
        exp_q.push_back(e);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            exp_t e, a;
            e = exp_q.pop_front();
            a = e;
            a.cmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            a.addr = sd_addr; a.ba = sd_ba; a.cke = sd_cke;
            a.busy = init_busy; a.done = init_done; a.fix = cas_fixed;
            n_checks++;
            if (a != e) begin
                n_fail++;
                $display("FAIL %s (R9 cke, R7 fix incl.) actual cmd=%b addr=%h ba=%0d cke=%b busy=%b done=%b fix=%b expected cmd=%b addr=%h ba=%0d cke=%b busy=%b done=%b fix=%b",
                    e.tag, a.cmd, a.addr, a.ba, a.cke, a.busy, a.done, a.fix,
                    e.cmd, e.addr, e.ba, e.cke, e.busy, e.done, e.fix);
            end
        end
    end

    // Driver: reset with a mode word, check reset state, queue the schedule
    task automatic run_seq(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                           input logic wb, input bit scramble);
        logic [2:0]  cl_exp;
        logic        fix;
        logic [11:0] word;
        @(negedge clk);
        rst_n = 1'b0; m_bl = bl; m_bt = bt; m_cl = cl; m_wb = wb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (!(sd_cs_n && init_busy && !init_done && sd_cke)) begin // R1
            n_fail++;
            $display("FAIL R1 reset state actual cs_n=%b busy=%b done=%b cke=%b expected 1 1 0 1",
                     sd_cs_n, init_busy, init_done, sd_cke);
        end
        fix    = !(cl == 3'd2 || cl == 3'd3);
        cl_exp = fix ? 3'd3 : cl;
        word   = {2'b00, wb, 2'b00, cl_exp, bt, bl};
        for (int i = 0; i < PW; i++) push("R2", 4'b0111, 12'h000, 1'b0, fix);
        push("R3", 4'b0010, 12'h400, 1'b0, fix);
        for (int i = 0; i < TRP - 1; i++) push("R4", 4'b0111, 12'h000, 1'b0, fix);
        push("R4", 4'b0001, 12'h000, 1'b0, fix);
        for (int i = 0; i < TRFC - 1; i++) push("R5", 4'b0111, 12'h000, 1'b0, fix);
        push("R5", 4'b0001, 12'h000, 1'b0, fix);
        for (int i = 0; i < TRFC - 1; i++) push("R5", 4'b0111, 12'h000, 1'b0, fix);
        push(scramble ? "R10" : "R6", 4'b0000, word, 1'b0, fix);
        for (int i = 0; i < TMRD - 1; i++) push("R8", 4'b0111, 12'h000, 1'b0, fix);
        for (int i = 0; i < 6; i++) push("R8", 4'b0111, 12'h000, 1'b1, fix);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;
        if (scramble) begin // R10: inputs change after release
            @(negedge clk);
            m_bl = ~bl; m_bt = ~bt; m_cl = 3'd6; m_wb = ~wb;
        end
        wait (exp_q.size() == 0);
        @(posedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        run_seq(3'd3, 1'b1, 3'd2, 1'b1, 1'b0);  // R6 legal CL 2
        run_seq(3'd7, 1'b0, 3'd3, 1'b0, 1'b1);  // R10 scrambled inputs
        run_seq(3'd1, 1'b0, 3'd5, 1'b0, 1'b0);  // R7 reserved CL 5
        run_seq(3'd2, 1'b1, 3'd0, 1'b1, 1'b0);  // R7 reserved CL 0
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=sequence complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule